// File: doc/BRIEF.md
# Instruction prefetch queue

This block sits between a memory bus port and an instruction consumer. It keeps a code segment register and a fetch offset, forms a 20-bit physical address from them, and asks for a 16-bit code word whenever its byte queue has at least two free places and no earlier request is still waiting for data. Each returned word is split into bytes in little-endian order and appended to a small FIFO. The consumer always reads the oldest byte of that FIFO and pops it with a take strobe.

A redirect pulse carries a new segment and offset. In the cycle it is seen, every queued byte is thrown away and the fetch pointer is loaded with the new target. Data from a request that was already in flight at that moment is dropped when it comes back. A target at an odd offset causes an aligned word fetch, and only the upper byte of that word enters the queue. Every later fetch is word-aligned.

Top module: `pfq_unit`

## Requirements
- R1: The request address on `mem_addr` equals (segment × 16 + word-aligned offset) modulo 2^20, where the word-aligned offset is the fetch offset with bit 0 cleared.
- R2: `mem_req` is high only when at most DEPTH−2 bytes are queued and no accepted request is still waiting for `mem_rvalid`. With no bytes taken, the queue settles with `mem_req` low.
- R3: Bytes leave in address order, oldest first. A returned word adds its byte from bits 7:0 (even address) before its byte from bits 15:8 (odd address).
- R4: While the queue is empty, `byte_valid` is low and a `byte_take` pulse has no effect: the next byte delivered is still the next byte of the stream.
- R5: A `redirect` pulse empties the queue, so `byte_valid` is low in the following cycle. The next request is made at the new target, and the bytes that follow start at that target.
- R6: For an odd target offset, the request address is even, and the first byte delivered is the one at the odd target address.
- R7: If a request is still outstanding when `redirect` is seen, its returning data never enters the queue.
- R8: The offset wraps from FFFFh to 0000h inside the same segment.
- R9: During reset `byte_valid` is low. After reset, fetching starts at the reset segment:offset (1234h:0022h by default, physical 12362h).
- R10: The queue holds up to DEPTH (default 6) bytes. With fetching stopped after fill-up, exactly DEPTH bytes can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect | input | 1 | Control transfer: flush and load new target |
| redirect_seg | input | 16 | New code segment value |
| redirect_ofs | input | 16 | New offset within the segment |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 20 | Even physical address of the requested word |
| mem_accept | input | 1 | Bus takes the request when high together with `mem_req` |
| mem_rvalid | input | 1 | Requested word is on `mem_rdata` |
| mem_rdata | input | 16 | Returned code word, lower address in bits 7:0 |
| byte_valid | output | 1 | Queue head holds a byte |
| byte_data | output | 8 | Oldest queued byte |
| byte_take | input | 1 | Pop the head byte (ignored when empty) |

## Verification
A redirect is registered on the rising edge that sees it. From the next cycle `byte_valid` is low and `mem_addr` shows the new target. A returned word is written on the edge that sees `mem_rvalid`, so `byte_valid` rises one cycle later, and a take pops on its edge, so the next head byte is visible in the following cycle. The bench drives every input and reads every output at the falling edge, so each check falls one half-cycle after the edge that produced the value. A bench memory model returns words one cycle after acceptance, or later when a delay is set. The expected bytes are computed from segment:offset arithmetic on that model's contents.

// File: rtl/pfq_pkg.sv
// Package: shared types for the prefetch queue.
// Assumes a two-byte bus word; push codes tell the FIFO how many bytes to append.
package pfq_pkg;
    typedef enum logic [1:0] {
        PUSH_NONE = 2'd0,
        PUSH_ONE  = 2'd1,
        PUSH_TWO  = 2'd2
    } push_e;
endpackage

// File: rtl/pfq_addr_gen.sv
// Module: pfq_addr_gen
// Forms the physical fetch address as segment shifted left by SHIFT plus offset.
// Assumes the result is wanted modulo 2^ADDR_W; the carry out of the top bit is dropped.
module pfq_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);
    localparam int BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0] base;

    // Segment base and wrapped sum.
    always_comb begin
        base = {seg, {SHIFT{1'b0}}};
        addr = ADDR_W'(base) + ADDR_W'(ofs);
    end
endmodule

// File: rtl/pfq_fifo.sv
// Module: pfq_fifo
// Byte FIFO of DEPTH entries that appends zero, one or two bytes per cycle and pops one.
// Assumes the writer never pushes more than the free space; flush clears everything at once.
module pfq_fifo
    import pfq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  push_e             push,
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              not_empty
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr, wr_nxt;
    logic              do_pop;
    logic [CNT_W-1:0]  n_push, n_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Pop qualification, next write slot and per-cycle byte counts.
    always_comb begin
        not_empty = (count != '0);
        do_pop    = pop && not_empty;
        wr_nxt    = step(wr_ptr);
        head      = mem[rd_ptr];
        n_pop     = do_pop ? CNT_W'(1) : '0;
        case (push)
            PUSH_ONE: n_push = CNT_W'(1);
            PUSH_TWO: n_push = CNT_W'(2);
            default:  n_push = '0;
        endcase
    end

    // Byte storage writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push != PUSH_NONE && PTR_W'(i) == wr_ptr)
                mem[i] <= b0;
            if (push == PUSH_TWO && PTR_W'(i) == wr_nxt)
                mem[i] <= b1;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= step(rd_ptr);
            if (push == PUSH_ONE)
                wr_ptr <= wr_nxt;
            else if (push == PUSH_TWO)
                wr_ptr <= step(wr_nxt);
            count <= count + n_push - n_pop;
        end
    end
endmodule

// File: rtl/pfq_fetch_ctl.sv
// Module: pfq_fetch_ctl
// Holds the segment and fetch offset, issues one word request at a time when two bytes are free,
// and turns returned words into push commands. A redirect reloads the target and marks any
// outstanding request stale so its data is dropped.
// Assumes at most one outstanding request and that mem_rvalid only follows an accepted request.
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int DEPTH = 6,
    parameter logic [SEG_W-1:0] RST_SEG = 16'h1234,
    parameter logic [OFS_W-1:0] RST_OFS = 16'h0022,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect,
    input  logic [SEG_W-1:0] seg_in,
    input  logic [OFS_W-1:0] ofs_in,
    input  logic             mem_accept,
    input  logic             mem_rvalid,
    input  logic [CNT_W-1:0] fill_count,
    output logic             mem_req,
    output logic [SEG_W-1:0] cur_seg,
    output logic [OFS_W-1:0] fetch_ofs,
    output push_e            push
);
    logic [OFS_W-1:0] ofs_q;
    logic             busy, stale, skip_low;

    // Request decision, aligned offset and push command.
    always_comb begin
        fetch_ofs = {ofs_q[OFS_W-1:1], 1'b0};
        mem_req   = !busy && !redirect && (fill_count <= CNT_W'(DEPTH - 2));
        if (mem_rvalid && busy && !stale && !redirect)
            push = skip_low ? PUSH_ONE : PUSH_TWO;
        else
            push = PUSH_NONE;
    end

    // Target registers and outstanding-request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_seg  <= RST_SEG;
            ofs_q    <= RST_OFS;
            busy     <= 1'b0;
            stale    <= 1'b0;
            skip_low <= 1'b0;
        end else begin
            if (redirect) begin
                cur_seg <= seg_in;
                ofs_q   <= ofs_in;
            end else if (mem_req && mem_accept) begin
                ofs_q    <= fetch_ofs + OFS_W'(2);
                skip_low <= ofs_q[0];
            end
            if (mem_req && mem_accept)
                busy <= 1'b1;
            else if (mem_rvalid)
                busy <= 1'b0;
            if (mem_rvalid)
                stale <= 1'b0;
            else if (redirect && busy)
                stale <= 1'b1;
        end
    end
endmodule

// File: rtl/pfq_unit.sv
// Module: pfq_unit (top)
// Instruction prefetch queue: address generation, fetch control and byte FIFO.
// Assumes a bus that returns exactly one word per accepted request, lower address in the low byte.
module pfq_unit
    import pfq_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8,
    parameter logic [SEG_W-1:0] RST_SEG = 16'h1234,
    parameter logic [OFS_W-1:0] RST_OFS = 16'h0022,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [SEG_W-1:0]  redirect_seg,
    input  logic [OFS_W-1:0]  redirect_ofs,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_accept,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_take
);
    logic [SEG_W-1:0]  cur_seg;
    logic [OFS_W-1:0]  fetch_ofs;
    logic [CNT_W-1:0]  fill_count;
    push_e             push;
    logic [BYTE_W-1:0] in_b0, in_b1;

    // Byte steering: a single push carries only the upper byte.
    always_comb begin
        in_b0 = (push == PUSH_ONE) ? mem_rdata[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
        in_b1 = mem_rdata[WORD_W-1:BYTE_W];
    end

    pfq_addr_gen #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
    ) u_addr (
        .seg(cur_seg), .ofs(fetch_ofs), .addr(mem_addr)
    );

    pfq_fetch_ctl #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .RST_SEG(RST_SEG), .RST_OFS(RST_OFS)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .redirect(redirect),
        .seg_in(redirect_seg), .ofs_in(redirect_ofs),
        .mem_accept(mem_accept), .mem_rvalid(mem_rvalid), .fill_count(fill_count),
        .mem_req(mem_req), .cur_seg(cur_seg), .fetch_ofs(fetch_ofs), .push(push)
    );

    pfq_fifo #(
        .DEPTH(DEPTH), .BYTE_W(BYTE_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(redirect), .push(push),
        .b0(in_b0), .b1(in_b1), .pop(byte_take),
        .head(byte_data), .count(fill_count), .not_empty(byte_valid)
    );
endmodule

// File: rtl/pfq_checker.sv
// Module: pfq_checker
// Property checks on the prefetch queue, attached to pfq_unit by the bind below.
// Tracks outstanding requests from the bus handshake on its own.
module pfq_checker #(
    parameter int DEPTH = 6,
    parameter int ADDR_W = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect,
    input logic              mem_req,
    input logic              mem_accept,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              byte_valid,
    input logic [CNT_W-1:0]  fill_count
);
    logic outst;

    // Outstanding request as seen on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outst <= 1'b0;
        else if (mem_req && mem_accept)
            outst <= 1'b1;
        else if (mem_rvalid)
            outst <= 1'b0;
    end

    // R2: no new request while one is outstanding.
    a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> !mem_req);

    // R2: a request needs two free places.
    a_r2_room: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (fill_count <= CNT_W'(DEPTH - 2)));

    // R10: occupancy never exceeds the depth.
    a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    // R5: a redirect leaves the queue empty.
    a_r5_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !byte_valid);

    // R6: requested words are always even-addressed.
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R4: an empty queue stays empty when no data returns.
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !mem_rvalid) |=> !byte_valid);
endmodule

bind pfq_unit pfq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pfq_chk (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .mem_req(mem_req),
    .mem_accept(mem_accept), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr),
    .byte_valid(byte_valid), .fill_count(fill_count)
);

// File: tb/test_pfq_unit.sv
// Directed bench for pfq_unit: a memory model answers requests, tasks check each scenario.
module test_pfq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_seg = '0;
    logic [15:0] redirect_ofs = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_accept = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_take = 1'b0;

    int checks = 0;
    int errors = 0;
    int mem_delay = 0;
    int cycles = 0;

    pfq_unit i_pfq_unit (
        .clk(clk), .rst_n(rst_n), .redirect(redirect),
        .redirect_seg(redirect_seg), .redirect_ofs(redirect_ofs),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_accept(mem_accept),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_take(byte_take)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_b(input logic [15:0] s, input logic [15:0] o, input int k);
        logic [15:0] oo;
        logic [19:0] pa;
        oo = o + 16'(k);
        pa = {s, 4'h0} + {4'h0, oo};
        return mb(pa);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Memory model: one word per accepted request, after mem_delay extra cycles.
    initial begin
        logic [19:0] a;
        forever begin
            @(posedge clk);
            if (mem_req && mem_accept) begin
                a = mem_addr;
                repeat (mem_delay) @(negedge clk);
                @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = {mb(a + 20'd1), mb(a)};
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
                finish_run();
            end
        end
    end

    // Wait for a byte at the head, compare it, then pop it. Enters and leaves at a falling edge.
    task automatic take_byte(input string tag, input logic [7:0] exp);
        int guard = 0;
        while (!byte_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " byte_valid"}, 32'(byte_valid), 32'd1);
        chk({tag, " byte_data"}, 32'(byte_data), 32'(exp));
        byte_take = 1'b1;
        @(negedge clk);
        byte_take = 1'b0;
    endtask

    task automatic do_redirect(input logic [15:0] s, input logic [15:0] o, input logic [19:0] exp_addr,
                               input string tag);
        redirect_seg = s;
        redirect_ofs = o;
        redirect = 1'b1;
        @(negedge clk);
        redirect = 1'b0;
        chk({tag, " flush byte_valid"}, 32'(byte_valid), 32'd0);
        chk({tag, " target mem_addr"}, 32'(mem_addr), 32'(exp_addr));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mem_accept = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 byte_valid in reset", 32'(byte_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 first mem_req", 32'(mem_req), 32'd1);
        chk("R9 R1 reset address", 32'(mem_addr), 32'h12362);
        mem_accept = 1'b1;
    endtask

    task automatic t_stream();
        for (int k = 0; k < 10; k++)
            take_byte("R3 reset stream", exp_b(16'h1234, 16'h0022, k));
    endtask

    task automatic t_fill_and_empty();
        do_redirect(16'h4000, 16'h0010, 20'h40010, "R5 fill");
        repeat (20) @(negedge clk);
        chk("R2 no request when full", 32'(mem_req), 32'd0);
        mem_accept = 1'b0;
        begin
            int n = 0;
            while (byte_valid && n < 10) begin
                chk("R10 full contents", 32'(byte_data), 32'(exp_b(16'h4000, 16'h0010, n)));
                byte_take = 1'b1;
                @(negedge clk);
                byte_take = 1'b0;
                n++;
            end
            chk("R10 bytes held", 32'(n), 32'd6);
        end
        for (int i = 0; i < 3; i++) begin
            byte_take = 1'b1;
            @(negedge clk);
            byte_take = 1'b0;
            chk("R4 empty stays empty", 32'(byte_valid), 32'd0);
        end
        mem_accept = 1'b1;
        take_byte("R4 take on empty ignored", exp_b(16'h4000, 16'h0010, 6));
    endtask

    task automatic t_redirect_wrap20();
        repeat (10) @(negedge clk);
        do_redirect(16'hFFFF, 16'hFFF0, 20'h0FFE0, "R1 R5 wrap20");
        for (int k = 0; k < 4; k++)
            take_byte("R5 new target stream", exp_b(16'hFFFF, 16'hFFF0, k));
    endtask

    task automatic t_odd();
        do_redirect(16'h2000, 16'h0105, 20'h20104, "R6 odd");
        for (int k = 0; k < 5; k++)
            take_byte("R6 odd target stream", exp_b(16'h2000, 16'h0105, k));
    endtask

    task automatic t_inflight();
        int guard = 0;
        mem_delay = 4;
        do_redirect(16'h5000, 16'h0000, 20'h50000, "R7 first");
        while (!mem_req && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk("R2 no request while outstanding", 32'(mem_req), 32'd0);
        do_redirect(16'h6000, 16'h0040, 20'h60040, "R7 second");
        for (int k = 0; k < 4; k++)
            take_byte("R7 stale data dropped", exp_b(16'h6000, 16'h0040, k));
        mem_delay = 0;
    endtask

    task automatic t_ofs_wrap();
        do_redirect(16'h3000, 16'hFFFC, 20'h3FFFC, "R8");
        for (int k = 0; k < 8; k++)
            take_byte("R8 offset wrap", exp_b(16'h3000, 16'hFFFC, k));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_fill_and_empty();
        t_redirect_wrap20();
        t_odd();
        t_inflight();
        t_ofs_wrap();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule